// File: doc/BRIEF.md
# Inverting Quad-Pumped Bus Receiver

This block receives a 64-bit active-low data bus that carries four transfers (sub-phases) in every common bus clock. Each 16-bit lane group has its own sub-phase strobe, inversion flag and parity bit. The block runs on a sampling clock that is faster than the bus clock. An input marks the last sampling cycle of each common clock. In every sampling cycle where a group's strobe is active, the block captures that group's 16 bits into the next sub-phase slot of that group. It restores the logical polarity, undoes any inversion the sender applied, and records a parity result for that group and sub-phase.

At the end of each common clock the four sub-phases are assembled into a 256-bit word. If data-ready was active, the block presents the word with a one-cycle valid pulse. The pulse comes with a parity error vector, a framing flag and a burst-end flag. In common clocks where data-ready is inactive the block produces nothing: the word output holds and all flags stay low.

Top module: `qp_bus_rx`

## Requirements
- R1: All bus inputs are active low. A data bit driven as 0 on the wire is a logical 1. With the inversion flag inactive (`inv_n` high), every restored bit is the complement of its wire level.
- R2: If group g's inversion flag is active (`inv_n[g]` low) when a bit set is captured, the logical bits of that group and sub-phase are complemented before they are placed in the word. Other groups and other sub-phases are not affected.
- R3: The word is laid out as follows: sub-phase p occupies `word_out[p*64 +: 64]`, and group g within it occupies bits `[p*64 + g*16 +: 16]`. Sub-phase 0 is in the least significant 64 bits.
- R4: Each group counts its own strobes. The k-th strobe of group g in a common clock (k = 0..3) captures into sub-phase k of that group, whatever the other groups do. All counts return to zero after the last sampling cycle of each common clock.
- R5: Parity is even and is taken over the 16 logical received bits plus the logical parity bit, before the inversion is undone. A failure of group g in sub-phase p sets `perr[p*4+g]`. `perr` is all zero when `word_vld` is low.
- R6: `word_vld` pulses for exactly the one cycle after a sampling cycle in which `cc_last` is high and `drdy_n` is low. No other cycle raises it. In every other cycle `word_out` holds its value.
- R7: `frame_err` is raised with `word_vld` when any group's strobe count in that common clock differs from four. A sub-phase that was not strobed reads as zero. Strobes beyond the fourth are ignored.
- R8: `burst_end` is raised with `word_vld` when `dbsy_n` is high (bus busy released) in the `cc_last` cycle of that common clock. Otherwise `burst_end` stays low.
- R9: Reset (`rst_n` low) clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cc_last | input | 1 | Last sampling cycle of the current common clock |
| drdy_n | input | 1 | Data-ready, active low, sampled in the cc_last cycle |
| dbsy_n | input | 1 | Bus busy, active low, sampled in the cc_last cycle |
| stb_n | input | 4 | Per-group sub-phase strobe, active low |
| inv_n | input | 4 | Per-group inversion flag, active low |
| par_n | input | 4 | Per-group parity bit, active low |
| d_n | input | 64 | Data bus, active low |
| word_out | output | 256 | Assembled, restored word |
| word_vld | output | 1 | One-cycle valid pulse |
| perr | output | 16 | Parity error per sub-phase and group |
| frame_err | output | 1 | Strobe count other than four in a valid clock |
| burst_end | output | 1 | Bus busy released at the end of this valid clock |

## Verification
A capture takes effect at the sampling edge of its strobe cycle. All results of a common clock (word, valid, parity vector, framing and burst-end flags) appear together one cycle after the edge that ends the `cc_last` cycle. The bench drives inputs on falling edges. It checks the results at the first falling edge after that closing edge, where all of them must be valid at once. It also checks that `word_vld` is low at every falling edge while a common clock is still being driven, which confirms the pulse lasts one cycle. Skewed strobe offsets per group, short and long strobe counts, and idle clocks cover the per-group counting and the hold behaviour.

// File: rtl/qp_bus_rx.sv
module qp_bus_rx #(
  parameter int GRP_W  = 16,
  parameter int GROUPS = 4,
  parameter int PHASES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cc_last,
  input  logic                             drdy_n,
  input  logic                             dbsy_n,
  input  logic [GROUPS-1:0]                stb_n,
  input  logic [GROUPS-1:0]                inv_n,
  input  logic [GROUPS-1:0]                par_n,
  input  logic [GRP_W*GROUPS-1:0]          d_n,
  output logic [GRP_W*GROUPS*PHASES-1:0]   word_out,
  output logic                             word_vld,
  output logic [PHASES*GROUPS-1:0]         perr,
  output logic                             frame_err,
  output logic                             burst_end
);
  localparam int BUS_W  = GRP_W * GROUPS;
  localparam int WORD_W = BUS_W * PHASES;
  localparam int PE_W   = PHASES * GROUPS;
  localparam int CNT_W  = $clog2(PHASES + 2);

  logic              win;
  logic [WORD_W-1:0] asm_d;
  logic [PE_W-1:0]   pe_d;
  logic [GROUPS-1:0] cnt_ok;

  assign win = cc_last && !drdy_n;

  for (genvar g = 0; g < GROUPS; g++) begin : gl
    logic [GRP_W-1:0] rx, fixed;
    logic             hit, bad;
    logic [CNT_W-1:0] cnt, cnt_nx;

    assign rx     = ~d_n[g*GRP_W +: GRP_W];
    assign hit    = ~stb_n[g];
    assign bad    = (^rx) ^ ~par_n[g];
    assign fixed  = inv_n[g] ? rx : ~rx;
    assign cnt_nx = (hit && cnt != CNT_W'(PHASES + 1)) ? cnt + 1'b1 : cnt;
    assign cnt_ok[g] = (cnt_nx == CNT_W'(PHASES));

    always_ff @(posedge clk) begin
      if (!rst_n || cc_last) cnt <= '0;
      else                   cnt <= cnt_nx;
    end

    for (genvar p = 0; p < PHASES; p++) begin : ph
      logic             take, pe_q;
      logic [GRP_W-1:0] slot_q;

      assign take = hit && (cnt == CNT_W'(p));
      assign asm_d[p*BUS_W + g*GRP_W +: GRP_W] = take ? fixed : slot_q;
      assign pe_d[p*GROUPS + g] = take ? bad : pe_q;

      always_ff @(posedge clk) begin
        if (!rst_n || cc_last) begin
          slot_q <= '0;
          pe_q   <= 1'b0;
        end else begin
          slot_q <= asm_d[p*BUS_W + g*GRP_W +: GRP_W];
          pe_q   <= pe_d[p*GROUPS + g];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out  <= '0;
      word_vld  <= 1'b0;
      perr      <= '0;
      frame_err <= 1'b0;
      burst_end <= 1'b0;
    end else begin
      word_vld  <= win;
      perr      <= win ? pe_d : '0;
      frame_err <= win && !(&cnt_ok);
      burst_end <= win && dbsy_n;
      if (win) word_out <= asm_d;
    end
  end

  a_r6_valid_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(cc_last && !drdy_n));
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(cc_last && !drdy_n) |=> $stable(word_out));
  a_r5_perr_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (|perr) |-> word_vld);
  a_r7_frame_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> word_vld);
  a_r8_burst_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |-> word_vld);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && !(cc_last && !drdy_n) |=> !word_vld);
endmodule

// File: tb/sim_qp_bus_rx.sv
module sim_qp_bus_rx;
  localparam int CLK_NS = 10;

  logic         clk = 0, rst_n = 0, cc_last = 0, drdy_n = 1, dbsy_n = 1;
  logic [3:0]   stb_n = '1, inv_n = '1, par_n = '1;
  logic [63:0]  d_n = '1;
  logic [255:0] word_out;
  logic         word_vld, frame_err, burst_end;
  logic [15:0]  perr;

  int checks = 0, fails = 0;
  logic [255:0] exp_word = '0;
  int nstb [4];

  always #(CLK_NS/2) clk = ~clk;

  qp_bus_rx u0 (.clk(clk), .rst_n(rst_n), .cc_last(cc_last), .drdy_n(drdy_n),
    .dbsy_n(dbsy_n), .stb_n(stb_n), .inv_n(inv_n), .par_n(par_n), .d_n(d_n),
    .word_out(word_out), .word_vld(word_vld), .perr(perr),
    .frame_err(frame_err), .burst_end(burst_end));

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] restore(logic [15:0] rx, logic inv);
    return inv ? ~rx : rx;
  endfunction

  // pbad: 0 none, 1 random, 2 group 1 always; dmode: 0 random, 1 wire all zero
  // imode: 0 random, 1 all inverted, 2 none inverted
  task automatic run_cc(string tag, int len, bit rdy, bit rel, int pbad, int dmode, int imode);
    int off [4];
    int k [4];
    logic [255:0] w = '0;
    logic [15:0]  pe = '0;
    bit any_bad = 0;
    for (int g = 0; g < 4; g++) begin
      k[g] = 0;
      off[g] = (len > nstb[g]) ? int'($urandom % (len - nstb[g] + 1)) : 0;
    end
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      chk("R6 pulse width", 256'(word_vld), 256'(0));
      for (int g = 0; g < 4; g++) begin
        logic [15:0] rx;
        logic inv, par, hit;
        hit = (c >= off[g]) && (c < off[g] + nstb[g]);
        rx  = (dmode == 1) ? 16'hFFFF : 16'($urandom);
        inv = (imode == 1) ? 1'b1 : (imode == 2) ? 1'b0 : 1'($urandom);
        par = ^rx;
        if ((pbad == 1 && ($urandom % 6 == 0)) || (pbad == 2 && g == 1)) par = ~par;
        stb_n[g] = ~hit;
        inv_n[g] = ~inv;
        par_n[g] = ~par;
        d_n[g*16 +: 16] = ~rx;
        if (hit) begin
          if (k[g] < 4) begin
            w[k[g]*64 + g*16 +: 16] = restore(rx, inv);
            pe[k[g]*4 + g] = (^rx) ^ par;
          end
          k[g]++;
        end
      end
      cc_last = (c == len - 1);
      drdy_n  = ~rdy;
      dbsy_n  = rel;
    end
    @(negedge clk);
    cc_last = 0; stb_n = '1; drdy_n = 1; dbsy_n = 0;
    for (int g = 0; g < 4; g++) if (k[g] != 4) any_bad = 1;
    if (rdy) exp_word = w;
    chk("R6 valid", 256'(word_vld), 256'(rdy));
    chk(tag, word_out, exp_word);
    chk("R5 parity", 256'(perr), rdy ? 256'(pe) : 256'(0));
    chk("R7 framing", 256'(frame_err), 256'(rdy && any_bad));
    chk("R8 burst end", 256'(burst_end), 256'(rdy && rel));
  endtask

  task automatic set_n(int a, int b, int c, int d);
    nstb[0] = a; nstb[1] = b; nstb[2] = c; nstb[3] = d;
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R9 reset word", word_out, '0);
    chk("R9 reset flags", 256'({word_vld, perr, frame_err, burst_end}), 256'(0));
    rst_n = 1;
    @(negedge clk);
    set_n(4, 4, 4, 4);
    run_cc("R1 all ones", 4, 1, 0, 0, 1, 2);
    chk("R1 word ones", word_out, '1);
    run_cc("R2 inverted back", 4, 1, 0, 0, 1, 1);
    chk("R2 word zero", word_out, '0);
    run_cc("R2 R3 mixed", 4, 1, 0, 0, 0, 0);
    run_cc("R5 group1 parity", 4, 1, 0, 2, 0, 0);
    chk("R5 group1 bits", 256'(perr), 256'(16'h2222));
    set_n(3, 4, 4, 4);
    run_cc("R7 short group0", 5, 1, 0, 0, 0, 0);
    chk("R7 phase3 group0 zero", 256'(word_out[192 +: 16]), 256'(0));
    set_n(4, 4, 4, 5);
    run_cc("R7 extra group3", 6, 1, 0, 0, 0, 0);
    set_n(4, 4, 4, 4);
    run_cc("R6 idle hold", 4, 0, 1, 1, 0, 0);
    run_cc("R8 released", 4, 1, 1, 0, 0, 0);
    run_cc("R4 skewed", 7, 1, 0, 1, 0, 0);
    for (int i = 0; i < 300; i++) begin
      int len;
      len = 4 + int'($urandom % 4);
      for (int g = 0; g < 4; g++) begin
        int r;
        r = int'($urandom % 10);
        nstb[g] = (r == 0) ? 3 : (r == 1 && len >= 5) ? 5 : 4;
      end
      run_cc("R3 R4 random", len, ($urandom % 5) != 0, 1'($urandom), 1, 0, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule